// File: doc/BRIEF.md
# Two-Thread Fetch Selector with Address-Watch Sleep

This block decides, every cycle, which of two hardware threads may fetch on a simultaneously multithreaded front end. For each thread it keeps a saturating count of instructions in flight. The count rises by the amount fetched and falls by the amounts committed and squashed in the same cycle. Among the threads allowed to fetch, the one with the smaller count wins. Equal counts are settled by a programmed per-thread priority, and then by taking turns.

A thread can also park itself. It first arms a watch on an address. A later quiesce request then puts it to sleep, and it stays out of the fetch choice until a write to the same 64-byte line is observed. That write wakes the thread and drops the watch.

A thread is also held back while its share of a shared queue has reached half the queue depth and the other thread is active. This keeps one thread from filling the queue. The grant is a combinational function of the registered state and the current active, priority and occupancy inputs.

Top module: `smt_fetch_pick`

## Requirements
- R1: After reset both in-flight counts are 0, neither thread is asleep, and the first turn-taking tie goes to thread 0.
- R2: On each clock edge a thread's count becomes its old count plus its fetch amount, minus its commit and squash amounts, all from the same cycle. If the amounts taken away reach or exceed the total, the count becomes 0.
- R3: A count saturates at its maximum (2^CNT_W - 1). With nothing taken away, a further fetch leaves it there.
- R4: When both threads are eligible, the thread with the smaller count is granted (sel_tid_o = thread index).
- R5: When the counts are equal, the thread with the numerically larger priority value is granted.
- R6: When both the counts and the priorities are equal, the grant goes to a turn pointer. The pointer moves to the other thread after every grant decided this way, and to no other kind of grant.
- R7: A thread sleeps from the edge at which it sees quiesce while its watch is armed. An arm in the same cycle counts as armed. A quiesce with no armed watch has no effect.
- R8: While a thread is armed, an observed write whose address bits above bit 5 match the armed address wakes it and disarms it. A write to a different line has no effect. A later quiesce without a new arm has no effect.
- R9: A sleeping thread is never granted. If the other thread is eligible, that thread is granted.
- R10: A thread whose queue occupancy is at least QDEPTH/2 is not granted while the other thread is active. When the other thread is inactive, that limit does not apply.
- R11: An inactive thread is never granted. sel_valid_o is 0 when no thread is eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_active_i | input | 2 | Thread has a live context, bit per thread |
| thr_prio_i | input | 2*PRIO_W | Programmed priority per thread, thread 0 in low bits |
| fetch_amt_i | input | 2*AMT_W | Instructions fetched this cycle, per thread |
| commit_amt_i | input | 2*AMT_W | Instructions committed this cycle, per thread |
| squash_amt_i | input | 2*AMT_W | Instructions squashed this cycle, per thread |
| q_occ_i | input | 2*OCC_W | Shared queue entries held, per thread |
| arm_i | input | 2 | Arm the address watch, per thread |
| arm_addr_i | input | 2*ADDR_W | Address to watch, per thread |
| quiesce_i | input | 2 | Request sleep on the armed watch, per thread |
| snoop_valid_i | input | 1 | A store or coherence write is observed |
| snoop_addr_i | input | ADDR_W | Address of the observed write |
| sel_valid_o | output | 1 | A thread is granted fetch this cycle |
| sel_tid_o | output | 1 | Granted thread |
| inflight_o | output | 2*CNT_W | In-flight counts, thread 0 in low bits |
| asleep_o | output | 2 | Thread is sleeping on its watch |

## Verification
The bench builds the block with 4-bit counters, a 16-bit address and a queue depth of 8. With these values saturation at 15 is reached after three large fetches, and the occupancy limit of 4 comes up often under random occupancy values. Random write addresses are kept within four 64-byte lines, so that same-line wakes and other-line misses both happen often, next to directed cases for the line edges. A random phase varies amounts, priorities, activity and watch traffic. A reference model in the bench computes each grant from the requirements.

// File: rtl/smt_fp_pkg.sv
package smt_fp_pkg;
   localparam int unsigned NTHR = 2;

   // How the current grant was decided
   typedef enum logic [1:0] {
      WIN_NONE  = 2'd0,
      WIN_COUNT = 2'd1,
      WIN_PRIO  = 2'd2,
      WIN_TURN  = 2'd3
   } win_e;
endpackage

// File: rtl/smt_fp_ctr.sv
module smt_fp_ctr #(
   parameter int CNT_W = 6,
   parameter int AMT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AMT_W-1:0] add_i,
   input  logic [AMT_W-1:0] sub_a_i,
   input  logic [AMT_W-1:0] sub_b_i,
   output logic [CNT_W-1:0] cnt_o
);
   localparam int SW = ((CNT_W > AMT_W) ? CNT_W : AMT_W) + 2;
   localparam logic [SW-1:0] CMAX = SW'((1 << CNT_W) - 1);

   logic [SW-1:0] up, dn, diff;
   logic [CNT_W-1:0] nxt;

   always_comb begin
      up   = SW'(cnt_o) + SW'(add_i);
      dn   = SW'(sub_a_i) + SW'(sub_b_i);
      diff = up - dn;
      if (dn >= up)        nxt = '0;
      else if (diff > CMAX) nxt = CMAX[CNT_W-1:0];
      else                 nxt = diff[CNT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_o <= '0;
      else        cnt_o <= nxt;
   end
endmodule

// File: rtl/smt_fp_watch.sv
module smt_fp_watch #(
   parameter int ADDR_W  = 32,
   parameter int LINE_LG = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm_i,
   input  logic [ADDR_W-1:0] arm_addr_i,
   input  logic              quiesce_i,
   input  logic              wr_valid_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   output logic              asleep_o
);
   localparam int TAG_W = ADDR_W - LINE_LG;

   logic             armed_q, armed_n, sleep_n, hit;
   logic [TAG_W-1:0] tag_q;

   always_comb begin
      hit     = wr_valid_i && armed_q && (wr_addr_i[ADDR_W-1:LINE_LG] == tag_q);
      armed_n = arm_i ? 1'b1 : (hit ? 1'b0 : armed_q);
      sleep_n = (hit && !arm_i) ? 1'b0 : (asleep_o || (quiesce_i && armed_n));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q  <= 1'b0;
         asleep_o <= 1'b0;
         tag_q    <= '0;
      end else begin
         armed_q  <= armed_n;
         asleep_o <= sleep_n;
         if (arm_i) tag_q <= arm_addr_i[ADDR_W-1:LINE_LG];
      end
   end
endmodule

// File: rtl/smt_fp_pick.sv
module smt_fp_pick
   import smt_fp_pkg::*;
#(
   parameter int CNT_W  = 6,
   parameter int PRIO_W = 2,
   parameter int OCC_W  = 5,
   parameter int HALF   = 8
) (
   input  logic [1:0]         act_i,
   input  logic [1:0]         asleep_i,
   input  logic [2*OCC_W-1:0] occ_i,
   input  logic [2*CNT_W-1:0] cnt_i,
   input  logic [2*PRIO_W-1:0] prio_i,
   input  logic               turn_i,
   output logic               valid_o,
   output logic               tid_o,
   output win_e               win_o
);
   localparam logic [OCC_W-1:0] LIM = OCC_W'(HALF);

   logic [1:0] elig;

   for (genvar t = 0; t < 2; t++) begin : g_elig
      assign elig[t] = act_i[t] && !asleep_i[t] &&
                       !(act_i[1-t] && (occ_i[t*OCC_W +: OCC_W] >= LIM));
   end

   logic [CNT_W-1:0]  c0, c1;
   logic [PRIO_W-1:0] p0, p1;
   assign c0 = cnt_i[CNT_W-1:0];
   assign c1 = cnt_i[2*CNT_W-1:CNT_W];
   assign p0 = prio_i[PRIO_W-1:0];
   assign p1 = prio_i[2*PRIO_W-1:PRIO_W];

   always_comb begin
      valid_o = |elig;
      tid_o   = 1'b0;
      win_o   = WIN_NONE;
      if (elig == 2'b01)      tid_o = 1'b0;
      else if (elig == 2'b10) tid_o = 1'b1;
      else if (elig == 2'b11) begin
         if (c0 != c1) begin
            tid_o = (c1 < c0);
            win_o = WIN_COUNT;
         end else if (p0 != p1) begin
            tid_o = (p1 > p0);
            win_o = WIN_PRIO;
         end else begin
            tid_o = turn_i;
            win_o = WIN_TURN;
         end
      end
   end
endmodule

// File: rtl/smt_fetch_pick.sv
module smt_fetch_pick
   import smt_fp_pkg::*;
#(
   parameter int CNT_W   = 6,
   parameter int AMT_W   = 3,
   parameter int PRIO_W  = 2,
   parameter int ADDR_W  = 32,
   parameter int LINE_LG = 6,
   parameter int QDEPTH  = 16,
   localparam int OCC_W  = $clog2(QDEPTH + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [1:0]            thr_active_i,
   input  logic [2*PRIO_W-1:0]   thr_prio_i,
   input  logic [2*AMT_W-1:0]    fetch_amt_i,
   input  logic [2*AMT_W-1:0]    commit_amt_i,
   input  logic [2*AMT_W-1:0]    squash_amt_i,
   input  logic [2*OCC_W-1:0]    q_occ_i,
   input  logic [1:0]            arm_i,
   input  logic [2*ADDR_W-1:0]   arm_addr_i,
   input  logic [1:0]            quiesce_i,
   input  logic                  snoop_valid_i,
   input  logic [ADDR_W-1:0]     snoop_addr_i,
   output logic                  sel_valid_o,
   output logic                  sel_tid_o,
   output logic [2*CNT_W-1:0]    inflight_o,
   output logic [1:0]            asleep_o
);
   localparam int HALF = QDEPTH / 2;

   if (CNT_W < 2) begin : g_bad_cnt
      $error("CNT_W must be at least 2");
   end
   if (LINE_LG >= ADDR_W) begin : g_bad_line
      $error("LINE_LG must be below ADDR_W");
   end
   if (QDEPTH < 2 || (QDEPTH % 2) != 0) begin : g_bad_depth
      $error("QDEPTH must be even and at least 2");
   end

   for (genvar t = 0; t < NTHR; t++) begin : g_thr
      smt_fp_ctr #(.CNT_W(CNT_W), .AMT_W(AMT_W)) i_ctr (
         .clk    (clk),
         .rst_n  (rst_n),
         .add_i  (fetch_amt_i [t*AMT_W +: AMT_W]),
         .sub_a_i(commit_amt_i[t*AMT_W +: AMT_W]),
         .sub_b_i(squash_amt_i[t*AMT_W +: AMT_W]),
         .cnt_o  (inflight_o  [t*CNT_W +: CNT_W])
      );
      smt_fp_watch #(.ADDR_W(ADDR_W), .LINE_LG(LINE_LG)) i_watch (
         .clk       (clk),
         .rst_n     (rst_n),
         .arm_i     (arm_i[t]),
         .arm_addr_i(arm_addr_i[t*ADDR_W +: ADDR_W]),
         .quiesce_i (quiesce_i[t]),
         .wr_valid_i(snoop_valid_i),
         .wr_addr_i (snoop_addr_i),
         .asleep_o  (asleep_o[t])
      );
   end

   logic turn_q;
   win_e win;

   smt_fp_pick #(.CNT_W(CNT_W), .PRIO_W(PRIO_W), .OCC_W(OCC_W), .HALF(HALF)) i_pick (
      .act_i   (thr_active_i),
      .asleep_i(asleep_o),
      .occ_i   (q_occ_i),
      .cnt_i   (inflight_o),
      .prio_i  (thr_prio_i),
      .turn_i  (turn_q),
      .valid_o (sel_valid_o),
      .tid_o   (sel_tid_o),
      .win_o   (win)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 turn_q <= 1'b0;
      else if (win == WIN_TURN)   turn_q <= !sel_tid_o;
   end
endmodule

// File: rtl/smt_fetch_pick_chk.sv
module smt_fetch_pick_chk #(
   parameter int CNT_W  = 6,
   parameter int AMT_W  = 3,
   parameter int QDEPTH = 16,
   parameter int OCC_W  = 5
) (
   input logic               clk,
   input logic               rst_n,
   input logic [1:0]         thr_active_i,
   input logic [2*AMT_W-1:0] commit_amt_i,
   input logic [2*AMT_W-1:0] squash_amt_i,
   input logic [2*OCC_W-1:0] q_occ_i,
   input logic [1:0]         quiesce_i,
   input logic               snoop_valid_i,
   input logic               sel_valid_o,
   input logic               sel_tid_o,
   input logic [2*CNT_W-1:0] inflight_o,
   input logic [1:0]         asleep_o
);
   localparam logic [OCC_W-1:0] LIM  = OCC_W'(QDEPTH / 2);
   localparam logic [CNT_W-1:0] CMAX = '1;

   for (genvar t = 0; t < 2; t++) begin : g_chk
      localparam int O = 1 - t;

      // R9 / R11: the granted thread is active and awake
      p_grant_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (sel_valid_o && sel_tid_o == 1'(t)) |-> (thr_active_i[t] && !asleep_o[t]));

      // R10: a thread at its queue share is held back while the other is active
      p_queue_share_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (sel_valid_o && sel_tid_o == 1'(t) && thr_active_i[O])
         |-> (q_occ_i[t*OCC_W +: OCC_W] < LIM));

      // R4: grant never goes to the larger count when the other thread could fetch
      p_least_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (sel_valid_o && sel_tid_o == 1'(t) && thr_active_i[O] && !asleep_o[O] &&
          (!thr_active_i[t] || q_occ_i[O*OCC_W +: OCC_W] < LIM))
         |-> (inflight_o[t*CNT_W +: CNT_W] <= inflight_o[O*CNT_W +: CNT_W]));

      // R3: a full count with nothing taken away stays full
      p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (inflight_o[t*CNT_W +: CNT_W] == CMAX &&
          commit_amt_i[t*AMT_W +: AMT_W] == '0 && squash_amt_i[t*AMT_W +: AMT_W] == '0)
         |=> (inflight_o[t*CNT_W +: CNT_W] == CMAX));

      // R7: sleep only begins after a quiesce request
      p_sleep_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(asleep_o[t]) |-> $past(quiesce_i[t]));

      // R8: waking needs an observed write
      p_wake_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(asleep_o[t]) |-> $past(snoop_valid_i));

      // R9: a sleeping thread does not block the other one
      p_progress_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (asleep_o[t] && thr_active_i[O] && !asleep_o[O] &&
          q_occ_i[O*OCC_W +: OCC_W] < LIM)
         |-> (sel_valid_o && sel_tid_o == 1'(O)));
   end

   // R11: nothing granted when no thread is active
   p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_active_i == 2'b00) |-> !sel_valid_o);
endmodule

bind smt_fetch_pick smt_fetch_pick_chk #(
   .CNT_W(CNT_W), .AMT_W(AMT_W), .QDEPTH(QDEPTH), .OCC_W(OCC_W)
) i_chk (
   .clk(clk), .rst_n(rst_n), .thr_active_i(thr_active_i),
   .commit_amt_i(commit_amt_i), .squash_amt_i(squash_amt_i),
   .q_occ_i(q_occ_i), .quiesce_i(quiesce_i), .snoop_valid_i(snoop_valid_i),
   .sel_valid_o(sel_valid_o), .sel_tid_o(sel_tid_o),
   .inflight_o(inflight_o), .asleep_o(asleep_o)
);

// File: tb/test_smt_fetch_pick.sv
`timescale 1ns/100ps
module test_smt_fetch_pick;
   localparam int CNT_W = 4, AMT_W = 3, PRIO_W = 2, ADDR_W = 16, LINE_LG = 6, QDEPTH = 8;
   localparam int OCC_W = $clog2(QDEPTH + 1);
   localparam int CMAX = (1 << CNT_W) - 1;
   localparam int HALF = QDEPTH / 2;

   logic clk = 1'b0, rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [1:0] b_act, b_arm, b_qui;
   logic [PRIO_W-1:0] b_prio [2];
   logic [AMT_W-1:0]  b_fet [2], b_com [2], b_sq [2];
   logic [OCC_W-1:0]  b_occ [2];
   logic [ADDR_W-1:0] b_aad [2];
   logic b_snv;
   logic [ADDR_W-1:0] b_sna;

   logic sel_valid_o, sel_tid_o;
   logic [2*CNT_W-1:0] inflight_o;
   logic [1:0] asleep_o;

   smt_fetch_pick #(.CNT_W(CNT_W), .AMT_W(AMT_W), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W),
                    .LINE_LG(LINE_LG), .QDEPTH(QDEPTH)) i_smt_fetch_pick (
      .clk(clk), .rst_n(rst_n), .thr_active_i(b_act),
      .thr_prio_i({b_prio[1], b_prio[0]}),
      .fetch_amt_i({b_fet[1], b_fet[0]}), .commit_amt_i({b_com[1], b_com[0]}),
      .squash_amt_i({b_sq[1], b_sq[0]}), .q_occ_i({b_occ[1], b_occ[0]}),
      .arm_i(b_arm), .arm_addr_i({b_aad[1], b_aad[0]}), .quiesce_i(b_qui),
      .snoop_valid_i(b_snv), .snoop_addr_i(b_sna),
      .sel_valid_o(sel_valid_o), .sel_tid_o(sel_tid_o),
      .inflight_o(inflight_o), .asleep_o(asleep_o));

   int total = 0, bad = 0;
   bit done = 0;

   // reference state
   int m_cnt [2];
   bit m_arm [2], m_sl [2];
   int m_tag [2];
   bit m_turn;

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic bit elig(input int t);
      int o = 1 - t;
      return b_act[t] && !m_sl[t] && !(b_act[o] && int'(b_occ[t]) >= HALF);
   endfunction

   // expected grant: returns valid, tid, and whether it was a turn tie
   function automatic void exp_sel(output bit v, output bit tid, output bit turn);
      bit e0 = elig(0), e1 = elig(1);
      v = e0 || e1; tid = 0; turn = 0;
      if (e0 && !e1) tid = 0;
      else if (e1 && !e0) tid = 1;
      else if (e0 && e1) begin
         if (m_cnt[0] != m_cnt[1]) tid = (m_cnt[1] < m_cnt[0]);
         else if (b_prio[0] != b_prio[1]) tid = (b_prio[1] > b_prio[0]);
         else begin tid = m_turn; turn = 1; end
      end
   endfunction

   function automatic int cnt_of(input int t);
      return int'(inflight_o[t*CNT_W +: CNT_W]);
   endfunction

   // check this cycle, advance the model, move to the next falling edge
   task automatic step(input string tag);
      bit v, tid, turn;
      #1;
      exp_sel(v, tid, turn);
      chk({tag, " R11 valid"}, int'(sel_valid_o), int'(v));
      if (v) chk({tag, " R4 tid"}, int'(sel_tid_o), int'(tid));
      for (int t = 0; t < 2; t++) begin
         chk({tag, " R2 count"}, cnt_of(t), m_cnt[t]);
         chk({tag, " R7 sleep"}, int'(asleep_o[t]), int'(m_sl[t]));
      end
      if (turn) m_turn = !tid;
      for (int t = 0; t < 2; t++) begin
         int up = m_cnt[t] + int'(b_fet[t]);
         int dn = int'(b_com[t]) + int'(b_sq[t]);
         bit hit = b_snv && m_arm[t] && (int'(b_sna >> LINE_LG) == m_tag[t]);
         m_cnt[t] = (dn >= up) ? 0 : ((up - dn > CMAX) ? CMAX : up - dn);
         if (b_arm[t]) begin m_arm[t] = 1; m_tag[t] = int'(b_aad[t] >> LINE_LG); end
         else if (hit) m_arm[t] = 0;
         if (hit && !b_arm[t]) m_sl[t] = 0;
         else m_sl[t] = m_sl[t] || (b_qui[t] && m_arm[t]);
      end
      @(negedge clk);
   endtask

   task automatic idle();
      b_arm = '0; b_qui = '0; b_snv = 0; b_sna = '0;
      for (int t = 0; t < 2; t++) begin
         b_fet[t] = '0; b_com[t] = '0; b_sq[t] = '0;
      end
   endtask

   task automatic look();
      #0.2;
   endtask

   initial begin
      b_act = 2'b11; b_prio[0] = '0; b_prio[1] = '0;
      b_occ[0] = '0; b_occ[1] = '0; b_aad[0] = '0; b_aad[1] = '0;
      idle();
      for (int t = 0; t < 2; t++) begin m_cnt[t] = 0; m_arm[t] = 0; m_sl[t] = 0; m_tag[t] = 0; end
      m_turn = 0;
      void'($urandom(32'd20511));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state and first turn tie
      look();
      chk("R1 count0", cnt_of(0), 0);
      chk("R1 count1", cnt_of(1), 0);
      chk("R1 asleep", int'(asleep_o), 0);
      chk("R1 first tie to thread 0", int'(sel_tid_o), 0);
      step("R1");
      look(); chk("R6 turn moves to thread 1", int'(sel_tid_o), 1);
      step("R6");
      look(); chk("R6 turn back to thread 0", int'(sel_tid_o), 0);
      step("R6");

      // R5 priority on equal counts
      b_prio[1] = 2'd2;
      look(); chk("R5 higher prio thread 1", int'(sel_tid_o), 1);
      step("R5");
      look(); chk("R5 no turn taking", int'(sel_tid_o), 1);
      step("R5");
      b_prio[0] = 2'd3;
      look(); chk("R5 higher prio thread 0", int'(sel_tid_o), 0);
      step("R5");
      b_prio[0] = '0; b_prio[1] = '0;

      // R2 / R4 counting
      b_fet[0] = 3'd3; step("R2");
      idle(); look();
      chk("R2 count after fetch 3", cnt_of(0), 3);
      chk("R4 fewer in flight wins", int'(sel_tid_o), 1);
      b_com[0] = 3'd2; b_sq[0] = 3'd1; step("R2");
      idle(); look(); chk("R2 commit plus squash", cnt_of(0), 0);
      b_com[0] = 3'd5; step("R2");
      idle(); look(); chk("R2 floor at zero", cnt_of(0), 0);

      // R3 saturation
      b_fet[0] = 3'd7; step("R3"); step("R3"); step("R3");
      idle(); look(); chk("R3 saturated", cnt_of(0), CMAX);
      b_fet[0] = 3'd7; step("R3");
      idle(); look(); chk("R3 stays at max", cnt_of(0), CMAX);
      b_fet[0] = 3'd7; b_com[0] = 3'd1; step("R3");
      idle(); look(); chk("R3 net gain holds max", cnt_of(0), CMAX);
      b_com[0] = 3'd7; b_sq[0] = 3'd7; step("R3"); step("R3");
      idle(); step("R3");

      // R7 / R8 / R9 quiesce and wake
      b_qui[0] = 1; step("R7");
      idle(); look(); chk("R7 quiesce unarmed ignored", int'(asleep_o[0]), 0);
      b_arm[0] = 1; b_aad[0] = 16'h1240; step("R7");
      idle(); b_qui[0] = 1; step("R7");
      idle(); look(); chk("R7 asleep after arm and quiesce", int'(asleep_o[0]), 1);
      b_fet[1] = 3'd5; step("R9");
      idle(); look();
      chk("R9 awake thread granted", int'(sel_valid_o), 1);
      chk("R9 sleeping thread skipped", int'(sel_tid_o), 1);
      b_snv = 1; b_sna = 16'h1280; step("R8");
      idle(); look(); chk("R8 other line ignored", int'(asleep_o[0]), 1);
      b_snv = 1; b_sna = 16'h127F; step("R8");
      idle(); look(); chk("R8 same line wakes", int'(asleep_o[0]), 0);
      b_qui[0] = 1; step("R8");
      idle(); look(); chk("R8 disarmed after wake", int'(asleep_o[0]), 0);
      b_com[1] = 3'd5; step("R8");
      idle(); step("R8");

      // R10 / R11 queue share and activity
      b_occ[0] = 4'(HALF);
      look(); chk("R10 thread 0 held at its share", int'(sel_tid_o), 1);
      step("R10");
      b_act = 2'b01;
      look();
      chk("R10 limit lifted valid", int'(sel_valid_o), 1);
      chk("R10 limit lifted tid", int'(sel_tid_o), 0);
      step("R10");
      b_act = 2'b00;
      look(); chk("R11 none active", int'(sel_valid_o), 0);
      step("R11");
      b_act = 2'b10;
      look(); chk("R11 only thread 1", int'(sel_tid_o), 1);
      step("R11");
      b_act = 2'b11; b_occ[0] = '0;

      // random phase
      for (int i = 0; i < 3000; i++) begin
         for (int t = 0; t < 2; t++) begin
            b_act[t]  = ($urandom % 10) != 0;
            b_prio[t] = PRIO_W'($urandom % 2);
            b_occ[t]  = OCC_W'($urandom % (HALF + 3));
            b_fet[t]  = AMT_W'($urandom % 8);
            b_com[t]  = AMT_W'($urandom % 4);
            b_sq[t]   = (($urandom % 4) == 0) ? AMT_W'($urandom % 4) : '0;
            b_arm[t]  = ($urandom % 20) == 0;
            b_aad[t]  = ADDR_W'(16'h1000 + ($urandom % 256));
            b_qui[t]  = ($urandom % 8) == 0;
         end
         b_snv = ($urandom % 3) == 0;
         b_sna = ADDR_W'(16'h1000 + ($urandom % 256));
         step("R4 random");
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule